// File: doc/BRIEF.md
# USB PHY Power Sequencer

This block brings a high-speed USB PHY up and takes it down by stepping through a small set of control bits. It owns a general control word and a low-power word, and it watches a status word that the PLL drives. A power-up request first releases the PLL from reset and then sets the suspend-mode control. After that the block checks PLL lock once per microsecond, up to a fixed number of times. When lock is seen it sets the connect bit. When the check budget runs out it reports a timeout error and leaves connect cleared. A power-down request runs the steps in reverse order: it drops connect, clears suspend mode, and then puts the PLL back into reset.

A 2-bit routing input says which controller owns the port. Requests only run the sequence when the port is routed to the high-speed controller. For any other routing they complete at once with success and leave both owned words unchanged. While a sequence runs, `busy` stays high and any new request is ignored. Completion is signalled by a one-cycle `done` pulse, with `err` pulsing alongside it on a timeout.

Top module: `usbphy_pwr_seq`

## Requirements
- R1: After synchronous reset, `ctrl_reg` is 0x01 (PLL reset bit 0 set, connect bit 2 clear), `lpm_reg` is 0x0000, and `busy`, `done` and `err` are low.
- R2: A power-up request accepted on clock edge E0 clears `ctrl_reg` bit 0 at edge E0+1 and sets `lpm_reg` bit 14 (suspend mode) at edge E0+2. `busy` is high from E0 until the sequence ends.
- R3: PLL lock counts only when `phy_status` bits 9 and 8 are both 1. Either bit alone is treated as no lock.
- R4: Lock is sampled first at edge E0+3 and then once every CLK_MHZ cycles (1 µs), for at most LOCK_TRIES (20) samples.
- R5: When a sample sees lock, `ctrl_reg` bit 2 (connect) is set and `done` pulses on that same edge with `err` low. `busy` drops on that edge.
- R6: If none of the 20 samples sees lock, `done` and `err` pulse together on the edge of the 20th sample, that is E0+3+19·CLK_MHZ. Connect stays clear and suspend mode stays set.
- R7: A power-down request accepted at edge E0 clears connect at E0+1, clears suspend mode at E0+2, sets PLL reset at E0+3, and pulses `done` at E0+3.
- R8: If `route_sel` is not 2'b11 (the high-speed controller), a request pulses `done` at edge E0 with `err` low. `busy` stays low, and `ctrl_reg` and `lpm_reg` do not change.
- R9: Requests that arrive while `busy` is high are ignored and produce no extra `done`.
- R10: If power-up and power-down are requested in the same idle cycle, the power-down sequence runs.
- R11: `done` and `err` are single-cycle pulses, and `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_req | input | 1 | Power-up request, sampled when idle |
| pwr_off_req | input | 1 | Power-down request, sampled when idle |
| route_sel | input | 2 | Port routing selection; 2'b11 = high-speed controller |
| phy_status | input | 16 | General status word; bits 9 and 8 report PLL lock |
| ctrl_reg | output | 8 | General control word; bit 0 PLL reset, bit 2 connect |
| lpm_reg | output | 16 | Low-power word; bit 14 suspend mode |
| busy | output | 1 | High while a sequence is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle lock-timeout pulse, alongside `done` |

## Verification
The functions that can collide in one cycle are the two request inputs. They meet when both are raised in the same idle cycle, and they also meet when a request arrives during an active lock poll. The bench raises both requests together on a powered-up PHY. It judges the outcome by the control word one edge later: connect cleared with PLL reset still low means the power-down path was taken. It also pulses a request in the middle of a lock poll. The scoreboard then flags any completion pulse that has no queued expectation, and checks that the poll ends on its predicted cycle.

// File: rtl/usbphy_pkg.sv
package usbphy_pkg;

    localparam int CTRL_W          = 8;
    localparam int LP_W            = 16;
    localparam int STAT_W          = 16;
    localparam int ROUTE_W         = 2;

    localparam int CTRL_PLLRST_BIT = 0;
    localparam int CTRL_CONN_BIT   = 2;
    localparam int LP_SUSP_BIT     = 14;
    localparam int STAT_LOCK_LO    = 8;
    localparam int STAT_LOCK_HI    = 9;

    localparam logic [ROUTE_W-1:0] ROUTE_HS = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ON_RST,
        ST_ON_SUSP,
        ST_POLL,
        ST_OFF_CONN,
        ST_OFF_SUSP,
        ST_OFF_RST
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CLR_RST,
        OP_SET_SUSP,
        OP_SET_CONN,
        OP_CLR_CONN,
        OP_CLR_SUSP,
        OP_SET_RST
    } reg_op_e;

    typedef struct packed {
        logic done;
        logic err;
    } seq_result_t;

    function automatic logic pll_locked(input logic [STAT_W-1:0] s);
        return s[STAT_LOCK_HI] & s[STAT_LOCK_LO];
    endfunction

endpackage

// File: rtl/usbphy_us_tick.sv
module usbphy_us_tick #(
    parameter int CLK_MHZ = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CLK_MHZ - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt == '0) begin
            cnt <= RELOAD;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = (cnt == '0);
endmodule

// File: rtl/usbphy_seq_fsm.sv
module usbphy_seq_fsm
    import usbphy_pkg::*;
#(
    parameter int LOCK_TRIES = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               on_req,
    input  logic               off_req,
    input  logic [ROUTE_W-1:0] route,
    input  logic               locked,
    input  logic               tick,
    output reg_op_e            op,
    output logic               tick_restart,
    output logic               busy,
    output seq_result_t        result
);
    localparam int TRY_W = (LOCK_TRIES > 1) ? $clog2(LOCK_TRIES) : 1;
    localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(LOCK_TRIES - 1);

    seq_state_e       state;
    logic [TRY_W-1:0] tries;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            tries  <= '0;
            result <= '0;
        end else begin
            result <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (on_req || off_req) begin
                        if (route != ROUTE_HS) begin
                            result.done <= 1'b1;
                        end else if (off_req) begin
                            state <= ST_OFF_CONN;
                        end else begin
                            state <= ST_ON_RST;
                        end
                    end
                end
                ST_ON_RST:  state <= ST_ON_SUSP;
                ST_ON_SUSP: begin
                    state <= ST_POLL;
                    tries <= '0;
                end
                ST_POLL: begin
                    if (tick) begin
                        if (locked) begin
                            result.done <= 1'b1;
                            state       <= ST_IDLE;
                        end else if (tries == LAST_TRY) begin
                            result.done <= 1'b1;
                            result.err  <= 1'b1;
                            state       <= ST_IDLE;
                        end else begin
                            tries <= tries + 1'b1;
                        end
                    end
                end
                ST_OFF_CONN: state <= ST_OFF_SUSP;
                ST_OFF_SUSP: state <= ST_OFF_RST;
                ST_OFF_RST: begin
                    result.done <= 1'b1;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        op = OP_NONE;
        unique case (state)
            ST_ON_RST:   op = OP_CLR_RST;
            ST_ON_SUSP:  op = OP_SET_SUSP;
            ST_POLL:     op = (tick && locked) ? OP_SET_CONN : OP_NONE;
            ST_OFF_CONN: op = OP_CLR_CONN;
            ST_OFF_SUSP: op = OP_CLR_SUSP;
            ST_OFF_RST:  op = OP_SET_RST;
            default:     op = OP_NONE;
        endcase
    end

    assign tick_restart = (state == ST_ON_SUSP);
    assign busy         = (state != ST_IDLE);
endmodule

// File: rtl/usbphy_ctl_regs.sv
module usbphy_ctl_regs
    import usbphy_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_op_e           op,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [LP_W-1:0]   lp_q
);
    localparam logic [CTRL_W-1:0] CTRL_RST_VAL = CTRL_W'(1) << CTRL_PLLRST_BIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST_VAL;
            lp_q   <= '0;
        end else begin
            unique case (op)
                OP_CLR_RST:  ctrl_q[CTRL_PLLRST_BIT] <= 1'b0;
                OP_SET_RST:  ctrl_q[CTRL_PLLRST_BIT] <= 1'b1;
                OP_SET_CONN: ctrl_q[CTRL_CONN_BIT]   <= 1'b1;
                OP_CLR_CONN: ctrl_q[CTRL_CONN_BIT]   <= 1'b0;
                OP_SET_SUSP: lp_q[LP_SUSP_BIT]       <= 1'b1;
                OP_CLR_SUSP: lp_q[LP_SUSP_BIT]       <= 1'b0;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/usbphy_pwr_seq.sv
module usbphy_pwr_seq
    import usbphy_pkg::*;
#(
    parameter int CLK_MHZ    = 200,
    parameter int LOCK_TRIES = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_on_req,
    input  logic               pwr_off_req,
    input  logic [ROUTE_W-1:0] route_sel,
    input  logic [STAT_W-1:0]  phy_status,
    output logic [CTRL_W-1:0]  ctrl_reg,
    output logic [LP_W-1:0]    lpm_reg,
    output logic               busy,
    output logic               done,
    output logic               err
);
    reg_op_e     op;
    logic        tick;
    logic        tick_restart;
    seq_result_t result;

    usbphy_us_tick #(.CLK_MHZ(CLK_MHZ)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (tick_restart),
        .tick    (tick)
    );

    usbphy_seq_fsm #(.LOCK_TRIES(LOCK_TRIES)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .on_req       (pwr_on_req),
        .off_req      (pwr_off_req),
        .route        (route_sel),
        .locked       (pll_locked(phy_status)),
        .tick         (tick),
        .op           (op),
        .tick_restart (tick_restart),
        .busy         (busy),
        .result       (result)
    );

    usbphy_ctl_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ctrl_q (ctrl_reg),
        .lp_q   (lpm_reg)
    );

    assign done = result.done;
    assign err  = result.err;
endmodule

// File: rtl/usbphy_pwr_seq_chk.sv
module usbphy_pwr_seq_chk
    import usbphy_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               pwr_on_req,
    input logic               pwr_off_req,
    input logic [ROUTE_W-1:0] route_sel,
    input logic [CTRL_W-1:0]  ctrl_reg,
    input logic               busy,
    input logic               done,
    input logic               err
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R5
    conn_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_reg[CTRL_CONN_BIT]) |-> (done && !err));

    // R2
    rst_release_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_reg[CTRL_PLLRST_BIT]) |-> busy);

    // R7
    rst_set_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_reg[CTRL_PLLRST_BIT]) |-> (done && !busy));

    // R8
    bypass_route_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && (pwr_on_req || pwr_off_req) && route_sel != ROUTE_HS)
            |=> (done && !err && !busy && $stable(ctrl_reg)));
endmodule

bind usbphy_pwr_seq usbphy_pwr_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_on_req  (pwr_on_req),
    .pwr_off_req (pwr_off_req),
    .route_sel   (route_sel),
    .ctrl_reg    (ctrl_reg),
    .busy        (busy),
    .done        (done),
    .err         (err)
);

// File: tb/sim_usbphy_pwr_seq.sv
`timescale 1ns/1ps
module sim_usbphy_pwr_seq;
    localparam int T     = 200;
    localparam int TRIES = 20;

    typedef struct {
        int          cyc;
        bit          err;
        logic [7:0]  ctrl;
        logic [15:0] lp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        on_req = 1'b0;
    logic        off_req = 1'b0;
    logic [1:0]  route = 2'b11;
    logic [15:0] status = 16'h0000;
    logic [7:0]  ctrl;
    logic [15:0] lp;
    logic        busy, done, err;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    usbphy_pwr_seq #(.CLK_MHZ(T), .LOCK_TRIES(TRIES)) u0 (
        .clk(clk), .rst(rst), .pwr_on_req(on_req), .pwr_off_req(off_req),
        .route_sel(route), .phy_status(status), .ctrl_reg(ctrl),
        .lpm_reg(lp), .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (cyc %0d)", req, act, exp, cyc);
        end
    endtask

    // driver: raises a request for one cycle and queues the expected completion
    task automatic issue(input bit on, input bit off, input logic [1:0] rt,
                         input int delay, input bit e_err, input logic [7:0] e_ctrl,
                         input logic [15:0] e_lp, input string tag, output int c);
        exp_t e;
        @(negedge clk);
        on_req = on; off_req = off; route = rt;
        c = cyc;
        e.cyc = c + delay; e.err = e_err; e.ctrl = e_ctrl; e.lp = e_lp; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        on_req = 1'b0; off_req = 1'b0;
    endtask

    task automatic poke(input bit on, input bit off);
        @(negedge clk);
        on_req = on; off_req = off;
        @(negedge clk);
        on_req = 1'b0; off_req = 1'b0;
    endtask

    task automatic to_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: every done pulse must match the oldest queued expectation
    always @(negedge clk) begin
        if (!rst) begin
            if (err && !done) begin
                total++; bad++;
                $display("FAIL R11: err without done actual=1 expected=0");
            end
            if (done) begin
                total++;
                if (q.size() == 0) begin
                    bad++;
                    $display("FAIL R9: unexpected done at cyc %0d actual=1 expected=0", cyc);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (cyc != e.cyc || err !== e.err || ctrl !== e.ctrl || lp !== e.lp) begin
                        bad++;
                        $display("FAIL %s: actual cyc=%0d err=%b ctrl=%h lp=%h expected cyc=%0d err=%b ctrl=%h lp=%h",
                                 e.tag, cyc, err, ctrl, lp, e.cyc, e.err, e.ctrl, e.lp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctrl", 32'(ctrl), 32'h01);
        chk("R1 lp", 32'(lp), 32'h0);
        chk("R1 flags", {29'd0, busy, done, err}, 32'h0);

        // R2/R5 power-up with lock already present
        status = 16'h0300;
        issue(1, 0, 2'b11, 4, 0, 8'h04, 16'h4000, "R5 on-lock", c);
        chk("R2 busy", 32'(busy), 32'h1);
        to_cyc(c + 2);
        chk("R2 rst cleared", {ctrl, lp}, {8'h00, 16'h0000});
        to_cyc(c + 3);
        chk("R2 suspend set", {ctrl, lp}, {8'h00, 16'h4000});
        wait_idle();

        // R10 both requests at once: power-down wins
        issue(1, 1, 2'b11, 4, 0, 8'h01, 16'h0000, "R10 both", c);
        to_cyc(c + 2);
        chk("R10 off path", 32'(ctrl), 32'h00);
        wait_idle();

        // R3/R4 lock arrives only at the third sample; single bit first
        status = 16'h0100;
        issue(1, 0, 2'b11, 4 + 2 * T, 0, 8'h04, 16'h4000, "R4 third-sample lock", c);
        poke(0, 1); // R9 ignored while busy
        poke(1, 0); // R9 ignored while busy
        to_cyc(c + 3 + 2 * T);
        chk("R3 bit8 alone no connect", {31'd0, ctrl[2]}, 32'h0);
        chk("R3 still busy", 32'(busy), 32'h1);
        status = 16'h0300;
        wait_idle();

        // R7 power-down order
        issue(0, 1, 2'b11, 4, 0, 8'h01, 16'h0000, "R7 off", c);
        to_cyc(c + 2);
        chk("R7 connect cleared", {ctrl, lp}, {8'h00, 16'h4000});
        to_cyc(c + 3);
        chk("R7 suspend cleared", {ctrl, lp}, {8'h00, 16'h0000});
        wait_idle();

        // R6 timeout with bit9 alone
        status = 16'h0200;
        issue(1, 0, 2'b11, 4 + (TRIES - 1) * T, 1, 8'h00, 16'h4000, "R6 timeout", c);
        to_cyc(c + 3 + (TRIES - 1) * T);
        chk("R4 polling till 20th", 32'(busy), 32'h1);
        wait_idle();
        chk("R6 connect clear", 32'(ctrl), 32'h00);
        issue(0, 1, 2'b11, 4, 0, 8'h01, 16'h0000, "R7 off after timeout", c);
        wait_idle();

        // R8 other routing: immediate success, no register change
        issue(1, 0, 2'b01, 1, 0, 8'h01, 16'h0000, "R8 on bypass", c);
        chk("R8 no busy", 32'(busy), 32'h0);
        @(negedge clk);
        chk("R11 done single", 32'(done), 32'h0);
        status = 16'h0300;
        issue(1, 0, 2'b11, 4, 0, 8'h04, 16'h4000, "R5 on again", c);
        wait_idle();
        issue(0, 1, 2'b10, 1, 0, 8'h04, 16'h4000, "R8 off bypass", c);
        to_cyc(c + 3);
        chk("R8 regs kept", {ctrl, lp}, {8'h04, 16'h4000});
        issue(0, 1, 2'b11, 4, 0, 8'h01, 16'h0000, "R7 final off", c);
        wait_idle();

        chk("R9 no pending", 32'(q.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule